// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block arbitrates thirteen interrupt sources for a small microcontroller core. In source-index order, from 0 to 12, the sources are: external 0, timer 0, external 1, timer 1, serial port 1, timer 2, temperature ADC, SPI/I2C, supply monitor, energy DSP, RTC interval timer, watchdog and serial port 2. Serial port 1, timer 2 and serial port 2 each raise one request built from two flags. Every source has an enable bit and a priority bit, and a global enable gates all of them. The block picks one eligible request and reports it to the core. It does this only when the core signals an instruction boundary. The report is a registered take strobe, the vector address and the source index.

A two-bit in-service register records whether a low-level or a high-level service routine is running. A high-level request can interrupt a low-level routine. Nothing interrupts a high-level routine. A request at a blocked level stays pending until it can be served.

The core also reports two kinds of event: the completion of a return-from-interrupt, and any access to the enable or priority register. After either event, vectoring waits until one more instruction has completed.

Top module: `intvec_ctrl`

## Requirements
- R1: Among eligible requests of the same level, the lowest source index wins.
- R2: After a decision, `take` is high for exactly one cycle. In that cycle `src_idx` holds the winning index n and `vector` equals 0x0003 + 8·n.
- R3: Sources 4, 5 and 12 request when `req_main[n] | req_alt[n]` is set. For every other source, `req_alt[n]` has no effect.
- R4: A source is eligible only when `en_q[13]` (global enable) and `en_q[n]` are both 1.
- R5: A source whose `pri_q[n]` is 1 is high level. An eligible high-level request beats every low-level request.
- R6: A decision is made only in a cycle where `insn_done` is high. The strobe follows one cycle later.
- R7: A cycle with `ret_done` high makes no decision. The next `insn_done` pulse makes no decision either. A later pulse may decide.
- R8: Any cycle with `en_wr`, `en_rd`, `pri_wr` or `pri_rd` high blocks vectoring in the same way as R7.
- R9: A high-level request may preempt a running low-level routine. No request is taken while a high-level routine runs. A same-level request stays pending and is served after the return and the hold-off.
- R10: `in_service[1]` is set by a high-level take and `in_service[0]` by a low-level take. `ret_done` clears the highest set bit.
- R11: A synchronous active-high `rst` clears the enables, priorities, in-service bits, strobe, index and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_main | input | 13 | Primary request flag per source |
| req_alt | input | 13 | Second flag, used only by sources 4, 5, 12 |
| en_wr | input | 1 | Write strobe for the enable register |
| en_rd | input | 1 | Read indication for the enable register |
| en_wdata | input | 14 | Enable data; bit 13 is the global enable |
| pri_wr | input | 1 | Write strobe for the priority register |
| pri_rd | input | 1 | Read indication for the priority register |
| pri_wdata | input | 13 | Priority data, 1 = high level |
| insn_done | input | 1 | Instruction-boundary pulse |
| ret_done | input | 1 | Return-from-interrupt completed |
| take | output | 1 | One-cycle take-interrupt strobe |
| vector | output | 16 | Vector address of the taken source |
| src_idx | output | 4 | Index of the taken source |
| in_service | output | 2 | In-service bits {high, low} |
| en_q | output | 14 | Current enable register |
| pri_q | output | 13 | Current priority register |

## Verification
A wrong in-service bit shows up at the first instruction boundary after a new request arrives. A wrongly set bit makes a legal preemption or a pending request disappear, and `take` stays low. A wrongly cleared bit makes `take` rise while a high-level routine is running. A stuck hold flag shows at the second boundary after a return or a register access. If the flag is stuck high, `take` never rises. If it is stuck low, `take` rises one boundary too early. Errors in selection or vector calculation show in `src_idx` and `vector` in the strobe cycle itself, one clock after the deciding boundary.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
  localparam int unsigned VEC_W  = 16;
  localparam int unsigned LVL_LO = 0;
  localparam int unsigned LVL_HI = 1;
  typedef logic [VEC_W-1:0] vec_t;

  function automatic vec_t vec_addr(vec_t base, vec_t step, vec_t idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/intvec_src.sv
module intvec_src #(
  parameter int unsigned NSRC = 13,
  parameter logic [NSRC-1:0] PAIR_MASK = 13'b1_0000_0011_0000
) (
  input  logic [NSRC-1:0] req_main,
  input  logic [NSRC-1:0] req_alt,
  input  logic [NSRC-1:0] en,
  input  logic            glob_en,
  input  logic [NSRC-1:0] prio,
  output logic [NSRC-1:0] pend_hi,
  output logic [NSRC-1:0] pend_lo
);
  logic [NSRC-1:0] flag;
  logic [NSRC-1:0] elig;

  assign flag    = req_main | (req_alt & PAIR_MASK);
  assign elig    = flag & en & {NSRC{glob_en}};
  assign pend_hi = elig & prio;
  assign pend_lo = elig & ~prio;
endmodule

// File: rtl/intvec_pick.sv
module intvec_pick #(
  parameter int unsigned N     = 13,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intvec_level.sv
module intvec_level (
  input  logic       clk,
  input  logic       rst,
  input  logic       take_hi,
  input  logic       take_lo,
  input  logic       ret_done,
  input  logic       access,
  input  logic       insn_done,
  output logic [1:0] in_service,
  output logic       hold
);
  import intvec_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_service <= '0;
    end else if (ret_done) begin
      if (in_service[LVL_HI]) in_service[LVL_HI] <= 1'b0;
      else                    in_service[LVL_LO] <= 1'b0;
    end else if (take_hi) begin
      in_service[LVL_HI] <= 1'b1;
    end else if (take_lo) begin
      in_service[LVL_LO] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    hold <= 1'b0;
    else if (ret_done | access) hold <= 1'b1;
    else if (insn_done)         hold <= 1'b0;
  end
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
  parameter int unsigned NSRC  = 13,
  parameter int unsigned IDX_W = $clog2(NSRC),
  parameter logic [NSRC-1:0] PAIR_MASK = 13'b1_0000_0011_0000,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0008
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_main,
  input  logic [NSRC-1:0] req_alt,
  input  logic            en_wr,
  input  logic            en_rd,
  input  logic [NSRC:0]   en_wdata,
  input  logic            pri_wr,
  input  logic            pri_rd,
  input  logic [NSRC-1:0] pri_wdata,
  input  logic            insn_done,
  input  logic            ret_done,
  output logic            take,
  output logic [15:0]     vector,
  output logic [IDX_W-1:0] src_idx,
  output logic [1:0]      in_service,
  output logic [NSRC:0]   en_q,
  output logic [NSRC-1:0] pri_q
);
  import intvec_pkg::*;

  logic [NSRC-1:0] pend_hi, pend_lo;
  logic            hi_hit, lo_hit, hold, access, allow, go_hi, go_lo;
  logic [IDX_W-1:0] hi_idx, lo_idx, sel_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_wr)  en_q  <= en_wdata;
      if (pri_wr) pri_q <= pri_wdata;
    end
  end

  intvec_src #(.NSRC(NSRC), .PAIR_MASK(PAIR_MASK)) u_src (
    .req_main(req_main), .req_alt(req_alt), .en(en_q[NSRC-1:0]),
    .glob_en(en_q[NSRC]), .prio(pri_q), .pend_hi(pend_hi), .pend_lo(pend_lo)
  );

  intvec_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_hi (
    .vec(pend_hi), .hit(hi_hit), .idx(hi_idx)
  );

  intvec_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick_lo (
    .vec(pend_lo), .hit(lo_hit), .idx(lo_idx)
  );

  assign access  = en_wr | en_rd | pri_wr | pri_rd;
  assign allow   = insn_done & ~hold & ~ret_done & ~access;
  assign go_hi   = allow & hi_hit & ~in_service[LVL_HI];
  assign go_lo   = allow & ~hi_hit & lo_hit & (in_service == 2'b00);
  assign sel_idx = go_hi ? hi_idx : lo_idx;

  intvec_level u_level (
    .clk(clk), .rst(rst), .take_hi(go_hi), .take_lo(go_lo),
    .ret_done(ret_done), .access(access), .insn_done(insn_done),
    .in_service(in_service), .hold(hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take    <= 1'b0;
      src_idx <= '0;
      vector  <= '0;
    end else begin
      take <= go_hi | go_lo;
      if (go_hi | go_lo) begin
        src_idx <= sel_idx;
        vector  <= vec_addr(VEC_BASE, VEC_STEP, vec_t'(sel_idx));
      end
    end
  end
endmodule

// File: rtl/intvec_ctrl_chk.sv
module intvec_ctrl_chk #(
  parameter int unsigned NSRC  = 13,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en_wr,
  input logic             en_rd,
  input logic             pri_wr,
  input logic             pri_rd,
  input logic             insn_done,
  input logic             ret_done,
  input logic             take,
  input logic [IDX_W-1:0] src_idx,
  input logic [1:0]       in_service,
  input logic [NSRC:0]    en_q
);
  a_r6_take_after_boundary: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(insn_done));

  a_r7_return_blocks: assert property (@(posedge clk) disable iff (rst)
    ret_done |=> !take);

  a_r8_access_blocks: assert property (@(posedge clk) disable iff (rst)
    (en_wr || en_rd || pri_wr || pri_rd) |=> !take);

  a_r9_high_not_preempted: assert property (@(posedge clk) disable iff (rst)
    in_service[1] |=> !take);

  a_r10_take_marks_level: assert property (@(posedge clk) disable iff (rst)
    take |-> (in_service != 2'b00));

  a_r2_index_in_range: assert property (@(posedge clk) disable iff (rst)
    take |-> (src_idx < IDX_W'(NSRC)));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!take && in_service == 2'b00 && en_q == '0));
endmodule

bind intvec_ctrl intvec_ctrl_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .en_wr(en_wr), .en_rd(en_rd), .pri_wr(pri_wr),
  .pri_rd(pri_rd), .insn_done(insn_done), .ret_done(ret_done), .take(take),
  .src_idx(src_idx), .in_service(in_service), .en_q(en_q)
);

// File: tb/intvec_ctrl_test.sv
`timescale 1ns/1ps
module intvec_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] req_main = '0, req_alt = '0;
  logic        en_wr = 0, en_rd = 0, pri_wr = 0, pri_rd = 0;
  logic [13:0] en_wdata = '0;
  logic [12:0] pri_wdata = '0;
  logic        insn_done = 0, ret_done = 0;
  logic        take;
  logic [15:0] vector;
  logic [3:0]  src_idx;
  logic [1:0]  in_service;
  logic [13:0] en_q;
  logic [12:0] pri_q;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  intvec_ctrl uut (
    .clk(clk), .rst(rst), .req_main(req_main), .req_alt(req_alt),
    .en_wr(en_wr), .en_rd(en_rd), .en_wdata(en_wdata), .pri_wr(pri_wr),
    .pri_rd(pri_rd), .pri_wdata(pri_wdata), .insn_done(insn_done),
    .ret_done(ret_done), .take(take), .vector(vector), .src_idx(src_idx),
    .in_service(in_service), .en_q(en_q), .pri_q(pri_q)
  );

  // fields: enable(14) priority(13) req_main(13) req_alt(13) exp_take(1) exp_idx(4)
  localparam int NV = 13;
  localparam logic [57:0] TBL [NV] = '{
    {14'h3FFF, 13'h0000, 13'h0009, 13'h0000, 1'b1, 4'd0},   // R1
    {14'h3FFF, 13'h0000, 13'h0088, 13'h0000, 1'b1, 4'd3},   // R1
    {14'h3FFF, 13'h0080, 13'h0088, 13'h0000, 1'b1, 4'd7},   // R5
    {14'h1FFF, 13'h0000, 13'h0001, 13'h0000, 1'b0, 4'd0},   // R4 global off
    {14'h3FFB, 13'h0000, 13'h0004, 13'h0000, 1'b0, 4'd0},   // R4 own bit off
    {14'h3FFF, 13'h0000, 13'h0000, 13'h0010, 1'b1, 4'd4},   // R3
    {14'h3FFF, 13'h0000, 13'h0000, 13'h0020, 1'b1, 4'd5},   // R3
    {14'h3FFF, 13'h0000, 13'h0000, 13'h1000, 1'b1, 4'd12},  // R3
    {14'h3FFF, 13'h0000, 13'h0000, 13'h0040, 1'b0, 4'd0},   // R3 unpaired
    {14'h3FFF, 13'h0000, 13'h1000, 13'h0000, 1'b1, 4'd12},  // R2
    {14'h3FFF, 13'h0A00, 13'h0A02, 13'h0000, 1'b1, 4'd9},   // R1 R5
    {14'h3FFF, 13'h0000, 13'h0400, 13'h0000, 1'b1, 4'd10},  // R2
    {14'h3FFE, 13'h0000, 13'h0003, 13'h0000, 1'b1, 4'd1}    // R4
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    req_main = '0; req_alt = '0;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr_en(logic [13:0] v);
    @(negedge clk) begin en_wr = 1'b1; en_wdata = v; end
    @(negedge clk) en_wr = 1'b0;
  endtask

  task automatic wr_pri(logic [12:0] v);
    @(negedge clk) begin pri_wr = 1'b1; pri_wdata = v; end
    @(negedge clk) pri_wr = 1'b0;
  endtask

  task automatic boundary();
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
  endtask

  task automatic do_return();
    @(negedge clk) ret_done = 1'b1;
    @(negedge clk) ret_done = 1'b0;
  endtask

  task automatic expect_take(string tag, int idx, logic [1:0] lvl);
    chk({tag, " take"}, 32'(take), 32'd1);
    chk({tag, " idx"}, 32'(src_idx), 32'(idx));
    chk({tag, " vector"}, 32'(vector), 32'h3 + 32'd8 * 32'(idx));
    chk({tag, " level"}, 32'(in_service), 32'(lvl));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    // R11: reset clears previously written state
    do_reset();
    wr_en(14'h3FFF);
    wr_pri(13'h1FFF);
    do_reset();
    chk("R11 take", 32'(take), 0);
    chk("R11 en_q", 32'(en_q), 0);
    chk("R11 pri_q", 32'(pri_q), 0);
    chk("R11 in_service", 32'(in_service), 0);
    chk("R11 vector", 32'(vector), 0);
    chk("R11 src_idx", 32'(src_idx), 0);

    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr_en(TBL[k][57:44]);
      wr_pri(TBL[k][43:31]);
      req_main = TBL[k][30:18];
      req_alt  = TBL[k][17:5];
      boundary();
      chk("R8 first boundary after write", 32'(take), 0);
      boundary();
      if (TBL[k][4]) begin
        expect_take("R1 R2 R3 R4 R5 table", int'(TBL[k][3:0]),
                    TBL[k][31 + TBL[k][3:0]] ? 2'b10 : 2'b01);
        @(negedge clk);
        chk("R2 strobe one cycle", 32'(take), 0);
      end else begin
        chk("R3 R4 table no take", 32'(take), 0);
        chk("R4 no level", 32'(in_service), 0);
      end
    end

    // R6: no decision without a boundary pulse
    do_reset();
    wr_en(14'h3FFF);
    req_main = 13'h0001;
    boundary();
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R6 no boundary", 32'(take), 0);
    end
    boundary();
    expect_take("R6 boundary", 0, 2'b01);

    // R8: read access also holds off
    do_reset();
    wr_en(14'h3FFF);
    req_main = 13'h0001;
    boundary();
    @(negedge clk) en_rd = 1'b1;
    @(negedge clk) en_rd = 1'b0;
    boundary();
    chk("R8 read hold", 32'(take), 0);
    boundary();
    expect_take("R8 after hold", 0, 2'b01);

    // R9 R7 R10: same-level pending across return
    do_reset();
    wr_en(14'h3FFF);
    wr_pri(13'h0000);
    req_main = 13'h0008;
    boundary();
    boundary();
    expect_take("R9 low first", 3, 2'b01);
    req_main = 13'h000A;
    boundary();
    chk("R9 same level held", 32'(take), 0);
    do_return();
    chk("R10 return clears low", 32'(in_service), 0);
    chk("R7 return no take", 32'(take), 0);
    boundary();
    chk("R7 hold boundary", 32'(take), 0);
    boundary();
    expect_take("R9 pending served", 1, 2'b01);

    // R9 R10: preemption by high, no preemption of high
    do_reset();
    wr_en(14'h3FFF);
    wr_pri(13'h0104);
    req_main = 13'h0008;
    boundary();
    boundary();
    expect_take("R9 low running", 3, 2'b01);
    req_main = 13'h0108;
    boundary();
    expect_take("R9 high preempts", 8, 2'b11);
    req_main = 13'h010C;
    boundary();
    chk("R9 high not preempted", 32'(take), 0);
    do_return();
    chk("R10 return clears high bit", 32'(in_service), 32'd1);
    boundary();
    chk("R7 hold after return", 32'(take), 0);
    boundary();
    expect_take("R9 high after return", 2, 2'b11);
    do_return();
    chk("R10 first return", 32'(in_service), 32'd1);
    do_return();
    chk("R10 second return", 32'(in_service), 0);

    // R7: return coinciding with a boundary
    do_reset();
    wr_en(14'h3FFF);
    req_main = 13'h0020;
    boundary();
    boundary();
    expect_take("R7 setup", 5, 2'b01);
    @(negedge clk) begin ret_done = 1'b1; insn_done = 1'b1; end
    @(negedge clk) begin ret_done = 1'b0; insn_done = 1'b0; end
    chk("R7 coincident no take", 32'(take), 0);
    chk("R10 coincident level", 32'(in_service), 0);
    boundary();
    chk("R7 coincident hold", 32'(take), 0);
    boundary();
    expect_take("R7 after hold", 5, 2'b01);

    summary();
  end
endmodule